// File: doc/BRIEF.md
# SPI Master Phased Transaction Sequencer

This block drives one single-lane SPI master transaction each time the start input is pulsed while the block is idle. The transaction moves through a fixed sequence of phases: an optional chip-select lead-in, then command, address, dummy, write-data and read-data phases, and finally an optional chip-select tail. Every middle phase has its own enable. Each programmed length is held as the count minus one. A phase whose enable is clear costs no time at all.

Serial timing comes from `sclk_tick`, a one-cycle pulse from an external divider. One tick marks the end of each SPI clock period. After the start pulse the block waits for one tick to align, and that tick pulls chip select low. Each later tick closes one serial bit. During a clocked bit the serial clock leaves its idle level for exactly the tick cycle, and read data is sampled on that same edge. Command, address and write-data bits go out on `mosi`. Write data is fetched word by word through `wdata_idx`/`wdata_word`. Read bits are stored in a 16-word buffer that is read through `rd_idx`/`rd_word`.

Top module: `spi_phase_seq`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. `busy` drops by itself in the same cycle that `done` is high.
- R2: Enabled phases run in the order lead-in, command, address, dummy, write, read, tail, with no gap between them. Disabled phases take no ticks. `cs_n` is low for exactly the sum of the enabled phase lengths, in ticks. With no phase enabled, the transaction ends on the alignment tick.
- R3: The command phase sends `cmd_len`+1 bits of `cmd_val`. In MSB-first mode (`wr_lsb_first`=0) it starts at bit `cmd_len` and counts down. In LSB-first mode it starts at bit 0 and counts up.
- R4: The address phase sends `addr_len`+1 bits of `addr_val`, using the same write-side bit order as R3.
- R5: The dummy phase lasts `dummy_len`+1 ticks with `mosi` low. When `dummy_idle`=1, `sclk` stays at idle level for the whole phase.
- R6: Write-data bit j (j = 0..`data_len`) comes from word (j/32) mod 16. Within that word it is bit j mod 32 when `wr_lsb_first`=1, and bit 31-(j mod 32) otherwise.
- R7: Read-data bit j is sampled from `miso` on its closing tick. It is stored in buffer word (j/32) mod 16, at bit j mod 32 when `rd_lsb_first`=1 and at bit 31-(j mod 32) otherwise. All other buffer bits are left unchanged.
- R8: With `setup_en`=1, `cs_n` is low for `setup_time`+1 ticks before the first enabled middle phase, with no `sclk` pulse and `mosi` low.
- R9: With `hold_en`=1, `cs_n` stays low for `hold_time` extra ticks after the last data phase, with no `sclk` pulse. A `hold_time` of 0 adds nothing.
- R10: With `keep_cs`=1, `cs_n` stays low between transactions. Otherwise `cs_n` is high whenever no phase is in progress.
- R11: `done` is high for exactly one cycle, the cycle after the final tick, which is also the cycle in which the block releases chip select.
- R12: A `start` pulse while `busy` is high is ignored. The running transaction keeps its timing and no second transaction follows.
- R13: Outside a tick cycle `sclk` equals `ck_idle`. In a tick cycle of a clocked bit it equals the inverse of `ck_idle`. `mosi` is low outside the command, address and write-data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | One-cycle pulse that ends each SPI clock period |
| start | input | 1 | Start request pulse |
| miso | input | 1 | Serial input data |
| cmd_en | input | 1 | Command phase enable |
| addr_en | input | 1 | Address phase enable |
| dummy_en | input | 1 | Dummy phase enable |
| wdata_en | input | 1 | Write-data phase enable |
| rdata_en | input | 1 | Read-data phase enable |
| setup_en | input | 1 | Chip-select lead-in enable |
| hold_en | input | 1 | Chip-select tail enable |
| dummy_idle | input | 1 | Hold sclk idle during the dummy phase |
| wr_lsb_first | input | 1 | Write-side bit order, 1 = LSB first |
| rd_lsb_first | input | 1 | Read-side bit order, 1 = LSB first |
| keep_cs | input | 1 | Force chip select active |
| ck_idle | input | 1 | Idle level of sclk |
| cmd_val | input | 16 | Command value |
| cmd_len | input | 4 | Command bits minus one |
| addr_val | input | 32 | Address value |
| addr_len | input | 5 | Address bits minus one |
| dummy_len | input | 8 | Dummy ticks minus one |
| data_len | input | 18 | Data bits minus one |
| setup_time | input | 5 | Lead-in ticks minus one |
| hold_time | input | 5 | Tail ticks |
| wdata_word | input | 32 | Write word selected by wdata_idx |
| wdata_idx | output | 4 | Index of the write word in use |
| rd_idx | input | 4 | Read buffer word select |
| rd_word | output | 32 | Read buffer word |
| busy | output | 1 | Transaction in progress (start bit readback) |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output data |

## Verification
On every cycle, the assertions enforce several rules. `sclk` rests at its idle level between ticks, in the lead-in and in a gated dummy phase. `mosi` stays low outside the shifting phases. The phase state and bit counter freeze between ticks, even when start pulses arrive. `done` is a single cycle and coincides with `busy` falling. Only the bench scenarios can show the actual bit streams under both bit orders and the phase lengths seen at the pins. They also cover where read bits land in the buffer, the all-disabled and setup-to-hold paths, and that a start pulse during a transaction leaves its length unchanged.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_LAUNCH = 4'd1,
    PH_SETUP  = 4'd2,
    PH_CMD    = 4'd3,
    PH_ADDR   = 4'd4,
    PH_DUMMY  = 4'd5,
    PH_WDATA  = 4'd6,
    PH_RDATA  = 4'd7,
    PH_HOLD   = 4'd8
  } phase_e;

  localparam int PH_COUNT = 9;

  typedef struct packed {
    logic setup_en;
    logic cmd_en;
    logic addr_en;
    logic dummy_en;
    logic wdata_en;
    logic rdata_en;
    logic hold_en;
  } phase_en_t;

endpackage

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int CNT_W   = 18,
  parameter int CMD_LW  = 4,
  parameter int ADDR_LW = 5,
  parameter int DUM_LW  = 8,
  parameter int CS_TW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               tick,
  input  phase_en_t          en,
  input  logic [CMD_LW-1:0]  cmd_len,
  input  logic [ADDR_LW-1:0] addr_len,
  input  logic [DUM_LW-1:0]  dummy_len,
  input  logic [CNT_W-1:0]   data_len,
  input  logic [CS_TW-1:0]   setup_time,
  input  logic [CS_TW-1:0]   hold_time,
  output phase_e             phase,
  output logic [CNT_W-1:0]   cnt,
  output logic               done
);

  logic [PH_COUNT-1:0] ph_on;
  phase_e              follow;
  logic [CNT_W-1:0]    last_cnt;
  phase_e              phase_d;
  logic [CNT_W-1:0]    cnt_d;
  logic                done_d;
  logic                upd;

  // Which phases take part in this transaction
  always_comb begin
    ph_on           = '0;
    ph_on[PH_SETUP] = en.setup_en;
    ph_on[PH_CMD]   = en.cmd_en;
    ph_on[PH_ADDR]  = en.addr_en;
    ph_on[PH_DUMMY] = en.dummy_en;
    ph_on[PH_WDATA] = en.wdata_en;
    ph_on[PH_RDATA] = en.rdata_en;
    ph_on[PH_HOLD]  = en.hold_en && (hold_time != '0);
  end

  // First enabled phase after the current one (lowest index wins)
  always_comb begin
    follow = PH_IDLE;
    for (int i = PH_COUNT - 1; i >= 2; i--) begin
      if (i > int'(phase) && ph_on[i]) follow = phase_e'(i[3:0]);
    end
  end

  // Final count value for the current phase
  always_comb begin
    case (phase)
      PH_SETUP: last_cnt = CNT_W'(setup_time);
      PH_CMD:   last_cnt = CNT_W'(cmd_len);
      PH_ADDR:  last_cnt = CNT_W'(addr_len);
      PH_DUMMY: last_cnt = CNT_W'(dummy_len);
      PH_WDATA: last_cnt = data_len;
      PH_RDATA: last_cnt = data_len;
      PH_HOLD:  last_cnt = CNT_W'(hold_time) - CNT_W'(1);
      default:  last_cnt = '0;
    endcase
  end

  // Next-state logic
  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    done_d  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) phase_d = PH_LAUNCH;
      end
      PH_LAUNCH: begin
        if (tick) begin
          phase_d = follow;
          cnt_d   = '0;
          done_d  = (follow == PH_IDLE);
        end
      end
      default: begin
        if (tick) begin
          if (cnt == last_cnt) begin
            phase_d = follow;
            cnt_d   = '0;
            done_d  = (follow == PH_IDLE);
          end else begin
            cnt_d = cnt + CNT_W'(1);
          end
        end
      end
    endcase
  end

  assign upd = tick || (phase == PH_IDLE && start);

  // State registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (upd) begin
      phase <= phase_d;
      cnt   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_d;
  end

  // R2: counter stays inside the current phase window
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_LAUNCH) |-> (cnt <= last_cnt));

  // R2: nothing advances between ticks
  assert_stall_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !tick) |=> $stable(cnt));

  // R12: a start request during a transaction does not move the sequencer
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !tick && start) |=> $stable(phase));

  // R11: completion is a single-cycle pulse
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/spi_seq_tx.sv
module spi_seq_tx
  import spi_seq_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 18,
  localparam int CMD_LW   = $clog2(CMD_W),
  localparam int ADDR_LW  = $clog2(ADDR_W),
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  phase_e             phase,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               wr_lsb,
  input  logic [CMD_W-1:0]   cmd_val,
  input  logic [CMD_LW-1:0]  cmd_len,
  input  logic [ADDR_W-1:0]  addr_val,
  input  logic [ADDR_LW-1:0] addr_len,
  input  logic [WORD_W-1:0]  wdata_word,
  output logic [IDX_W-1:0]   wdata_idx,
  output logic               mosi
);

  logic [CMD_LW-1:0]  cmd_sel;
  logic [ADDR_LW-1:0] addr_sel;
  logic [BIT_W-1:0]   bit_sel;

  // LSB-first counts up from bit 0; MSB-first counts down from the top bit
  assign cmd_sel   = wr_lsb ? cnt[CMD_LW-1:0]  : (cmd_len  - cnt[CMD_LW-1:0]);
  assign addr_sel  = wr_lsb ? cnt[ADDR_LW-1:0] : (addr_len - cnt[ADDR_LW-1:0]);
  assign bit_sel   = wr_lsb ? cnt[BIT_W-1:0]   : ~cnt[BIT_W-1:0];
  assign wdata_idx = cnt[BIT_W +: IDX_W];

  always_comb begin
    case (phase)
      PH_CMD:   mosi = cmd_val[cmd_sel];
      PH_ADDR:  mosi = addr_val[addr_sel];
      PH_WDATA: mosi = wdata_word[bit_sel];
      default:  mosi = 1'b0;
    endcase
  end

endmodule

// File: rtl/spi_seq_rxbuf.sv
module spi_seq_rxbuf #(
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 18,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_lsb,
  input  logic              miso,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [IDX_W-1:0]  widx;
  logic [BIT_W-1:0]  pos;
  logic [WORD_W-1:0] words [BUF_WORDS];

  assign widx = cnt[BIT_W +: IDX_W];
  assign pos  = rd_lsb ? cnt[BIT_W-1:0] : ~cnt[BIT_W-1:0];

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = cap && (widx == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q      <= '0;
      else if (hit) word_q[pos] <= miso;
    end
    assign words[w] = word_q;
  end

  assign rd_word = words[rd_idx];

  // R7: the captured bit lands at the selected word and position
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (words[$past(widx)][$past(pos)] == $past(miso)));

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
  import spi_seq_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 18,
  parameter int DUM_LW    = 8,
  parameter int CS_TW     = 5,
  localparam int CMD_LW   = $clog2(CMD_W),
  localparam int ADDR_LW  = $clog2(ADDR_W),
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_tick,
  input  logic               start,
  input  logic               miso,
  input  logic               cmd_en,
  input  logic               addr_en,
  input  logic               dummy_en,
  input  logic               wdata_en,
  input  logic               rdata_en,
  input  logic               setup_en,
  input  logic               hold_en,
  input  logic               dummy_idle,
  input  logic               wr_lsb_first,
  input  logic               rd_lsb_first,
  input  logic               keep_cs,
  input  logic               ck_idle,
  input  logic [CMD_W-1:0]   cmd_val,
  input  logic [CMD_LW-1:0]  cmd_len,
  input  logic [ADDR_W-1:0]  addr_val,
  input  logic [ADDR_LW-1:0] addr_len,
  input  logic [DUM_LW-1:0]  dummy_len,
  input  logic [CNT_W-1:0]   data_len,
  input  logic [CS_TW-1:0]   setup_time,
  input  logic [CS_TW-1:0]   hold_time,
  input  logic [WORD_W-1:0]  wdata_word,
  output logic [IDX_W-1:0]   wdata_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic               busy,
  output logic               done,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi
);

  phase_en_t        en;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             clocked;
  logic             cs_active;

  assign en = '{setup_en: setup_en, cmd_en: cmd_en, addr_en: addr_en,
                dummy_en: dummy_en, wdata_en: wdata_en, rdata_en: rdata_en,
                hold_en: hold_en};

  spi_seq_fsm #(
    .CNT_W(CNT_W), .CMD_LW(CMD_LW), .ADDR_LW(ADDR_LW),
    .DUM_LW(DUM_LW), .CS_TW(CS_TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(sclk_tick), .en(en),
    .cmd_len(cmd_len), .addr_len(addr_len), .dummy_len(dummy_len),
    .data_len(data_len), .setup_time(setup_time), .hold_time(hold_time),
    .phase(phase), .cnt(cnt), .done(done)
  );

  spi_seq_tx #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)
  ) u_tx (
    .phase(phase), .cnt(cnt), .wr_lsb(wr_lsb_first),
    .cmd_val(cmd_val), .cmd_len(cmd_len), .addr_val(addr_val),
    .addr_len(addr_len), .wdata_word(wdata_word), .wdata_idx(wdata_idx),
    .mosi(mosi)
  );

  spi_seq_rxbuf #(
    .WORD_W(WORD_W), .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .cap(phase == PH_RDATA && sclk_tick),
    .cnt(cnt), .rd_lsb(rd_lsb_first), .miso(miso),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  // Serial clock leaves idle only in the tick cycle of a clocked bit
  always_comb begin
    case (phase)
      PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA: clocked = 1'b1;
      PH_DUMMY:                            clocked = !dummy_idle;
      default:                             clocked = 1'b0;
    endcase
  end

  assign cs_active = (phase != PH_IDLE) && (phase != PH_LAUNCH);
  assign cs_n      = !(cs_active || keep_cs);
  assign sclk      = ck_idle ^ (clocked && sclk_tick);
  assign busy      = (phase != PH_IDLE);

  // R1: the start bit reads back clear when completion is flagged
  assert_done_clears_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: chip select released when idle and not forced
  assert_cs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !keep_cs) |-> cs_n);

  // R13: serial clock rests between ticks
  assert_sclk_rest_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_tick |-> (sclk == ck_idle));

  // R13: data line quiet outside the shifting phases
  assert_mosi_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY || phase == PH_RDATA || phase == PH_HOLD || !busy) |-> !mosi);

  // R5: gated dummy phase keeps the clock idle
  assert_dummy_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY && dummy_idle) |-> (sclk == ck_idle));

  // R8: lead-in has chip select low, no clock and no data
  assert_setup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |-> (!cs_n && sclk == ck_idle && !mosi));

endmodule

// File: tb/spi_phase_seq_bench.sv
`timescale 1ns/1ps
module spi_phase_seq_bench;

  logic clk, rst_n, sclk_tick, start, miso;
  logic cmd_en, addr_en, dummy_en, wdata_en, rdata_en, setup_en, hold_en;
  logic dummy_idle, wr_lsb_first, rd_lsb_first, keep_cs, ck_idle;
  logic [15:0] cmd_val;
  logic [3:0]  cmd_len;
  logic [31:0] addr_val;
  logic [4:0]  addr_len;
  logic [7:0]  dummy_len;
  logic [17:0] data_len;
  logic [4:0]  setup_time, hold_time;
  logic [31:0] wdata_word, rd_word;
  logic [3:0]  wdata_idx, rd_idx;
  logic busy, done, cs_n, sclk, mosi;

  logic [31:0] wmem   [16];
  logic [31:0] rmodel [16];
  logic        exp_mosi [1024];
  logic        exp_clk  [1024];
  int          seg      [1024];
  logic        rbit     [1024];
  int pre_rd, rd_n, total;
  int errors = 0, checks = 0;

  assign wdata_word = wmem[wdata_idx];

  spi_phase_seq u_spi_phase_seq (
    .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .start(start), .miso(miso),
    .cmd_en(cmd_en), .addr_en(addr_en), .dummy_en(dummy_en), .wdata_en(wdata_en),
    .rdata_en(rdata_en), .setup_en(setup_en), .hold_en(hold_en),
    .dummy_idle(dummy_idle), .wr_lsb_first(wr_lsb_first), .rd_lsb_first(rd_lsb_first),
    .keep_cs(keep_cs), .ck_idle(ck_idle), .cmd_val(cmd_val), .cmd_len(cmd_len),
    .addr_val(addr_val), .addr_len(addr_len), .dummy_len(dummy_len),
    .data_len(data_len), .setup_time(setup_time), .hold_time(hold_time),
    .wdata_word(wdata_word), .wdata_idx(wdata_idx), .rd_idx(rd_idx),
    .rd_word(rd_word), .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string seg_tag(input int s);
    case (s)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Expected bit stream from the requirements
  task automatic build();
    int p = 0;
    if (setup_en) for (int i = 0; i <= int'(setup_time); i++) begin
      exp_mosi[p] = 0; exp_clk[p] = 0; seg[p] = 8; p++; end
    if (cmd_en) for (int i = 0; i <= int'(cmd_len); i++) begin
      exp_mosi[p] = cmd_val[wr_lsb_first ? i : int'(cmd_len) - i];
      exp_clk[p] = 1; seg[p] = 3; p++; end
    if (addr_en) for (int i = 0; i <= int'(addr_len); i++) begin
      exp_mosi[p] = addr_val[wr_lsb_first ? i : int'(addr_len) - i];
      exp_clk[p] = 1; seg[p] = 4; p++; end
    if (dummy_en) for (int i = 0; i <= int'(dummy_len); i++) begin
      exp_mosi[p] = 0; exp_clk[p] = !dummy_idle; seg[p] = 5; p++; end
    if (wdata_en) for (int j = 0; j <= int'(data_len); j++) begin
      exp_mosi[p] = wmem[(j / 32) % 16][wr_lsb_first ? j % 32 : 31 - j % 32];
      exp_clk[p] = 1; seg[p] = 6; p++; end
    pre_rd = p;
    rd_n = rdata_en ? int'(data_len) + 1 : 0;
    for (int j = 0; j < rd_n; j++) begin
      rbit[j] = 1'($urandom);
      rmodel[(j / 32) % 16][rd_lsb_first ? j % 32 : 31 - j % 32] = rbit[j];
      exp_mosi[p] = 0; exp_clk[p] = 1; seg[p] = 7; p++;
    end
    if (hold_en) for (int i = 0; i < int'(hold_time); i++) begin
      exp_mosi[p] = 0; exp_clk[p] = 0; seg[p] = 9; p++; end
    total = p;
  endtask

  task automatic run_txn(input bit inject);
    build();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    #1 check(busy == 1, "R1 busy after start", busy, 1);
    for (int k = 0; k <= total; k++) begin
      int gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk) start = inject && ($urandom % 2 == 0);
        #1 check(sclk == ck_idle, "R13 sclk rest", sclk, ck_idle);
        if (start) check(busy == 1, "R12 busy kept", busy, 1);
      end
      @(negedge clk) start = 0; sclk_tick = 1;
      if (k >= 1 && k - 1 >= pre_rd && k - 1 < pre_rd + rd_n) miso = rbit[k - 1 - pre_rd];
      else miso = 1'($urandom);
      #1;
      if (k == 0) begin
        check(cs_n == !keep_cs, "R8 cs before first tick", cs_n, !keep_cs);
        check(sclk == ck_idle, "R13 sclk align tick", sclk, ck_idle);
      end else begin
        check(cs_n == 0, "R2 cs low in phases", cs_n, 0);
        check(mosi == exp_mosi[k - 1], seg_tag(seg[k - 1]), mosi, exp_mosi[k - 1]);
        check(sclk == (ck_idle ^ exp_clk[k - 1]), "R13 sclk pulse", sclk, ck_idle ^ exp_clk[k - 1]);
      end
      @(negedge clk) sclk_tick = 0;
      #1;
      if (k == total) begin
        check(done == 1, inject ? "R12 done on time" : "R11 done", done, 1);
        check(busy == 0, "R1 busy self-clear", busy, 0);
        check(cs_n == !keep_cs, "R10 cs after end", cs_n, !keep_cs);
      end else begin
        check(done == 0, "R11 no early done", done, 0);
      end
    end
    @(negedge clk) #1;
    check(done == 0, "R11 single pulse", done, 0);
    check(busy == 0, "R12 no second transaction", busy, 0);
    for (int w = 0; w < 16; w++) begin
      rd_idx = 4'(w);
      #0.2 check(rd_word == rmodel[w], "R7 buffer word", rd_word, rmodel[w]);
    end
  endtask

  task automatic cfg_rand();
    {cmd_en, addr_en, dummy_en, wdata_en, rdata_en, setup_en, hold_en} = 7'($urandom);
    dummy_idle = 1'($urandom); wr_lsb_first = 1'($urandom);
    rd_lsb_first = 1'($urandom); keep_cs = ($urandom % 4 == 0); ck_idle = 1'($urandom);
    cmd_val = 16'($urandom); cmd_len = 4'($urandom);
    addr_val = $urandom; addr_len = 5'($urandom);
    dummy_len = 8'($urandom % 12); data_len = 18'($urandom % 120);
    setup_time = 5'($urandom % 8); hold_time = 5'($urandom % 8);
    for (int w = 0; w < 16; w++) wmem[w] = $urandom;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; sclk_tick = 0; start = 0; miso = 0; rd_idx = 0;
    {cmd_en, addr_en, dummy_en, wdata_en, rdata_en, setup_en, hold_en} = '0;
    dummy_idle = 0; wr_lsb_first = 0; rd_lsb_first = 0; keep_cs = 0; ck_idle = 0;
    cmd_val = 0; cmd_len = 0; addr_val = 0; addr_len = 0; dummy_len = 0;
    data_len = 0; setup_time = 0; hold_time = 0;
    for (int w = 0; w < 16; w++) begin wmem[w] = 0; rmodel[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(busy == 0, "R1 reset busy", busy, 0);
    check(done == 0, "R11 reset done", done, 0);
    check(cs_n == 1, "R10 reset cs", cs_n, 1);
    check(sclk == 0 && mosi == 0, "R13 reset lines", {sclk, mosi}, 0);

    // R2: nothing enabled, ends on the alignment tick
    run_txn(0);
    // R2 R8 R9: lead-in straight to tail
    setup_en = 1; hold_en = 1; setup_time = 3; hold_time = 2;
    run_txn(0);
    // R3 R4: full-width command MSB first, full-width address
    setup_en = 0; hold_en = 0; cmd_en = 1; addr_en = 1;
    cmd_len = 15; cmd_val = 16'hA5C3; addr_len = 31; addr_val = 32'h8123_4567;
    run_txn(0);
    wr_lsb_first = 1; run_txn(0);
    // R5: gated dummy, R10: forced chip select, R12: start injected
    dummy_en = 1; dummy_len = 5; dummy_idle = 1; keep_cs = 1; ck_idle = 1;
    run_txn(1);
    // R6 R7: long data, both orders
    keep_cs = 0; wdata_en = 1; rdata_en = 1; data_len = 70;
    for (int w = 0; w < 16; w++) wmem[w] = $urandom;
    run_txn(0);
    rd_lsb_first = 1; wr_lsb_first = 0; run_txn(1);

    for (int t = 0; t < 40; t++) begin
      cfg_rand();
      run_txn(t % 3 == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule